// File: doc/BRIEF.md
# Language Card Soft-Switch Controller

This block holds the four control flops of a RAM overlay that can replace ROM in the top part of the address map. The flops are: the upper-bank select, the RAM read enable, the write inhibit and an internal pre-write arming flop. The block watches every bus cycle. When a valid access falls inside a fixed 16-byte switch window, it updates the flops from the low address bits and from the access direction. Accesses outside the window leave every flop as it was.

The bank select, read enable and write inhibit go straight to the memory decoder. The decoder lets RAM be written in the overlay region only while the write inhibit is clear. The write inhibit is cleared only by an odd read that finds pre-write already armed. Pre-write takes its new value after the write-inhibit decision for the same access, so clearing the inhibit from a disarmed state takes two qualifying reads.

Top module: `lcard_switch_ctrl`

## Requirements
- R1: An access is in the window when `bus_valid` is high and `bus_addr[15:4]` equals `WIN_BASE[15:4]` (default 0xC08). A valid access outside the window leaves `bank_hi`, `ram_rd_en` and `wr_inhibit` unchanged.
- R2: Every window access, read or write, loads `bank_hi` from address bit 3.
- R3: Every window access sets `ram_rd_en` when address bits [1:0] are 00 or 11. It clears `ram_rd_en` when they are 01 or 10.
- R4: A window read (`bus_rd`=1) with address bit 0 clear sets `wr_inhibit`.
- R5: A window read with address bit 0 set clears `wr_inhibit`, but only if pre-write was already set before that access.
- R6: Every other access leaves `wr_inhibit` unchanged. This covers window writes, odd reads with pre-write clear, and accesses outside the window.
- R7: Every window access, read or write, loads pre-write from address bit 1. The new value takes effect only after the write-inhibit decision of that same access.
- R8: While the reset is active, and just after it ends, `bank_hi`=1, `ram_rd_en`=0 and `wr_inhibit`=1, with pre-write clear.
- R9: Start with pre-write clear. Two consecutive window reads at an address with bits [1:0]=11 then leave `wr_inhibit` set after the first read and clear after the second.
- R10: The outputs change on the rising clock edge that samples a valid window access. With `bus_valid` low, nothing changes, whatever the address.

Per-access effect on the flops (a = address bits [3:0]):

| Access | `bank_hi` | `ram_rd_en` | `wr_inhibit` | pre-write |
|---|---|---|---|---|
| Window read, a[0]=0 | a[3] | a[1:0] is 00 or 11 | set | a[1] |
| Window read, a[0]=1, pre-write set | a[3] | a[1:0] is 00 or 11 | cleared | a[1] |
| Window read, a[0]=1, pre-write clear | a[3] | a[1:0] is 00 or 11 | held | a[1] |
| Window write | a[3] | a[1:0] is 00 or 11 | held | a[1] |
| Outside window, or `bus_valid` low | held | held | held | held |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | One-cycle strobe marking a valid bus access |
| bus_rd | input | 1 | Access direction: 1 = read, 0 = write |
| bus_addr | input | ADDR_W (16) | Access address |
| bank_hi | output | 1 | Selects the second 4 KB bank of the overlay |
| ram_rd_en | output | 1 | Overlay reads return RAM when high, ROM when low |
| wr_inhibit | output | 1 | Overlay RAM writes are blocked when high |

## Verification
The assertions assume at most one access per clock, carried by a single-cycle `bus_valid` strobe. They also assume `bus_rd` and `bus_addr` are stable while the clock edge samples the strobe. They give no meaning to the bus while the internal reset is held.

The bench meets these assumptions as follows:
- It drives each access on the falling edge and drops the strobe on the next falling edge.
- It waits several cycles after releasing the reset, so the internal synchronizer has let go before the first access.
- It puts out-of-window addresses on the bus only with the strobe either high for a single cycle or low.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int unsigned WIN_BITS = 4;

  typedef struct packed {
    logic                hit;
    logic                rd;
    logic [WIN_BITS-1:0] low;
  } lcs_acc_t;
endpackage

// File: rtl/lcs_rst_sync.sv
module lcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/lcs_win_dec.sv
module lcs_win_dec
  import lcs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [15:0] WIN_BASE = 16'hC080
) (
  input  logic              valid_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output lcs_acc_t          acc_o
);
  localparam int unsigned TAG_W = ADDR_W - WIN_BITS;
  localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(WIN_BASE >> WIN_BITS);

  always_comb begin
    acc_o.hit = valid_i && (addr_i[ADDR_W-1:WIN_BITS] == WIN_TAG);
    acc_o.rd  = rd_i;
    acc_o.low = addr_i[WIN_BITS-1:0];
  end
endmodule

// File: rtl/lcs_bank_read.sv
module lcs_bank_read
  import lcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ni,
  input  lcs_acc_t acc_i,
  output logic     bank_o,
  output logic     rden_o
);
  logic bank_d, rden_d;
  logic load_en;

  always_comb begin
    load_en = acc_i.hit;
    bank_d  = acc_i.low[3];
    rden_d  = ~(acc_i.low[1] ^ acc_i.low[0]);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o <= 1'b1;
      rden_o <= 1'b0;
    end else if (load_en) begin
      bank_o <= bank_d;
      rden_o <= rden_d;
    end
  end

  // R2
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_i.hit |=> bank_o == $past(acc_i.low[3]));

  // R3
  rden_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_i.hit |=> rden_o == ($past(acc_i.low[1:0]) inside {2'b00, 2'b11}));

  // R1
  outside_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !acc_i.hit |=> $stable(bank_o) && $stable(rden_o));
endmodule

// File: rtl/lcs_wp_ctrl.sv
module lcs_wp_ctrl
  import lcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ni,
  input  lcs_acc_t acc_i,
  output logic     inhibit_o
);
  logic arm_q, arm_d;
  logic inhibit_d;
  logic arm_en;

  always_comb begin
    arm_en    = acc_i.hit;
    arm_d     = acc_i.low[1];
    inhibit_d = inhibit_o;
    if (acc_i.hit && acc_i.rd) begin
      if (!acc_i.low[0])  inhibit_d = 1'b1;
      else if (arm_q)     inhibit_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) inhibit_o <= 1'b1;
    else         inhibit_o <= inhibit_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     arm_q <= 1'b0;
    else if (arm_en) arm_q <= arm_d;
  end

  // R4
  even_read_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_i.hit && acc_i.rd && !acc_i.low[0]) |=> inhibit_o);

  // R5
  odd_armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_i.hit && acc_i.rd && acc_i.low[0] && arm_q) |=> !inhibit_o);

  // R6
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!acc_i.hit || !acc_i.rd || (acc_i.low[0] && !arm_q)) |=> $stable(inhibit_o));

  // R7
  arm_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_i.hit |=> arm_q == $past(acc_i.low[1]));
endmodule

// File: rtl/lcard_switch_ctrl.sv
module lcard_switch_ctrl
  import lcs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [15:0] WIN_BASE = 16'hC080,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bank_hi,
  output logic              ram_rd_en,
  output logic              wr_inhibit
);
  logic     rst_int_n;
  lcs_acc_t acc;

  lcs_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_int_n)
  );

  lcs_win_dec #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
    .valid_i (bus_valid),
    .rd_i    (bus_rd),
    .addr_i  (bus_addr),
    .acc_o   (acc)
  );

  lcs_bank_read u_bank (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .acc_i  (acc),
    .bank_o (bank_hi),
    .rden_o (ram_rd_en)
  );

  lcs_wp_ctrl u_wp (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .acc_i     (acc),
    .inhibit_o (wr_inhibit)
  );

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_valid |=> $stable(bank_hi) && $stable(ram_rd_en) && $stable(wr_inhibit));
endmodule

// File: tb/lcard_switch_ctrl_test.sv
`timescale 1ns/1ps
module lcard_switch_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bank_hi, ram_rd_en, wr_inhibit;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lcard_switch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bank_hi(bank_hi), .ram_rd_en(ram_rd_en),
    .wr_inhibit(wr_inhibit)
  );

  // Each entry: {rd, low nibble[3:0], exp bank, exp rden, exp inhibit}.
  // The comment gives the pre-write value after each access.
  localparam logic [7:0] VEC [0:14] = '{
    8'b1_0000_011, // pre 0, even read sets (R4)
    8'b1_0001_001, // pre 0, odd read, not armed (R6)
    8'b1_0011_011, // pre 1 (R7)
    8'b1_1011_110, // pre 1, armed odd read clears (R5)
    8'b0_1000_110, // pre 0, write holds (R6)
    8'b1_1001_100, // pre 0
    8'b1_1010_101, // pre 1
    8'b0_0001_001, // pre 0
    8'b0_0011_011, // pre 1, armed by a write (R7)
    8'b1_0101_000, // pre 0
    8'b1_1111_110, // pre 1
    8'b1_0100_011, // pre 0
    8'b1_0111_011, // pre 1
    8'b1_1110_101, // pre 1
    8'b1_1101_100  // pre 0
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic eb, input logic er, input logic ew);
    chk({tag, " bank_hi"},    bank_hi,    eb);
    chk({tag, " ram_rd_en"},  ram_rd_en,  er);
    chk({tag, " wr_inhibit"}, wr_inhibit, ew);
  endtask

  task automatic access(input logic rd, input logic [15:0] addr);
    @(negedge clk);
    bus_valid = 1'b1;
    bus_rd    = rd;
    bus_addr  = addr;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: values while the reset is held
    chk_all("R8 in reset", 1'b1, 1'b0, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R8: values after the reset ends
    chk_all("R8 after reset", 1'b1, 1'b0, 1'b1);

    // R2 R3 R4 R5 R6 R7: walk the vector table
    for (int i = 0; i < 15; i++) begin
      access(VEC[i][7], {12'hC08, VEC[i][6:3]});
      chk_all($sformatf("R2/R3/R4/R5/R6 vec %0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
    end
    // Now bank 1, rden 0, inhibit 0, pre 0.

    // R1: valid accesses outside the window change nothing
    access(1'b1, 16'hC090); chk_all("R1 C090 read", 1'b1, 1'b0, 1'b0);
    access(1'b1, 16'hC07C); chk_all("R1 C07C read", 1'b1, 1'b0, 1'b0);
    access(1'b0, 16'hD083); chk_all("R1 D083 write", 1'b1, 1'b0, 1'b0);
    access(1'b1, 16'h4084); chk_all("R1 4084 read", 1'b1, 1'b0, 1'b0);

    // R10: strobe low with a window address changes nothing
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 16'hC080;
    repeat (3) @(negedge clk);
    chk_all("R10 idle bus", 1'b1, 1'b0, 1'b0);

    // R10: the change is visible right after the sampling edge
    @(negedge clk);
    bus_valid = 1'b1; bus_rd = 1'b1; bus_addr = 16'hC080;
    chk_all("R10 before edge", 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    bus_valid = 1'b0;
    chk_all("R10 after edge", 1'b0, 1'b1, 1'b1);

    // R9: two odd reads at a[1:0]=11 from a fresh reset (pre clear)
    do_reset();
    access(1'b1, 16'hC083);
    chk("R9 first odd read inhibit", wr_inhibit, 1'b1);
    access(1'b1, 16'hC083);
    chk("R9 second odd read inhibit", wr_inhibit, 1'b0);

    // R8: a reset in mid-operation restores the reset values
    access(1'b1, 16'hC08B);
    do_reset();
    chk_all("R8 mid reset", 1'b1, 1'b0, 1'b1);

    // R7: a disarming write blocks the following odd read
    access(1'b1, 16'hC083);
    access(1'b0, 16'hC089);
    access(1'b1, 16'hC08B);
    chk("R7 disarmed by write", wr_inhibit, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule